// File: doc/BRIEF.md
# Configuration Cycle Address Generator

This block turns a configuration request, made of a bus number, a device slot, a function number and a register offset, into the two values a host bridge needs to launch a downstream configuration cycle. The first is a 24-bit offset inside a 16 MB configuration aperture. The second is a 16-bit control word for the configuration window. That word carries the cycle-type code, the upper device-select bits and the flag that controls the low address bits.

Requests for bus 0 produce a type 0 cycle. In a type 0 cycle the device is picked with a one-hot select bit. For slots 0 to 12 that bit lies in the aperture offset. For slots 13 to 20 it moves into the upper bits of the control word. Requests for any other bus produce a type 1 cycle, where bus, slot, function and offset are packed directly into the aperture offset.

Requests enter on a valid/ready stream and results leave on another. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the output holds no result or the consumer takes the held result in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, the result stays frozen and no new request is taken. A type 0 request whose slot has no select bit produces no result. Instead it raises a one-cycle error pulse.

Top module: `cfgaddr_gen`

## Requirements
- R1: A request with bus number 0 yields a type 0 result with control-word bit 0 = 0. Any other bus number yields a type 1 result with control-word bit 0 = 1.
- R2: Every result carries the cycle-type code 3'b101 in control-word bits 3:1.
- R3: For type 0 with slot 0..12, offset bit (slot+11) is the only bit set among offset bits 23:11, and control-word bits 15:4 are zero.
- R4: For type 0 with slot 13..20, control-word bit (slot-5) is the only bit set among control-word bits 15:4, and offset bits 23:11 are zero.
- R5: For type 0, offset bits 10:8 hold the function number, bits 7:2 hold register-offset bits 7:2, and bits 1:0 are zero whatever register-offset bits 1:0 are.
- R6: For type 1, the offset equals {bus[7:0], slot[4:0], func[2:0], regofs[7:0]} from bit 23 down to bit 0, and control-word bits 15:4 are zero.
- R7: A type 0 request with slot 21..31 is accepted. In the next cycle `cfg_err` is high for exactly one cycle and `rsp_valid` is low.
- R8: An accepted request without error gives `rsp_valid` high on the clock edge after it is taken, together with its result.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and the result outputs hold their value.
- R10: After reset, `rsp_valid` and `cfg_err` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken on this edge if valid |
| req_bus | input | 8 | Target bus number |
| req_slot | input | 5 | Device slot |
| req_func | input | 3 | Function number |
| req_regofs | input | 8 | Register offset |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_addr | output | 24 | Offset inside the configuration aperture |
| rsp_map | output | 16 | Configuration window control word |
| cfg_err | output | 1 | One-cycle pulse: type 0 slot without a select bit |

## Verification
The bench targets the edges of the select split: slot 12 (last offset bit) against slot 13 (first control-word bit), and slot 20 against 21. A design with an off-by-one split would set the wrong bit or set both places. Slots 21 to 31 on bus 0 must give the error pulse and no result, while the same slots on a non-zero bus must pass through untouched. A generator that checked the slot range regardless of cycle type would wrongly drop those type 1 requests. Register offsets with low bits set check that type 0 clears them and type 1 keeps them. A stalled consumer checks that the held result neither changes nor gets overwritten by a waiting request.

// File: rtl/cfgaddr_pkg.sv
package cfgaddr_pkg;
  typedef enum logic {
    CYC_LOCAL = 1'b0,
    CYC_FORWARD = 1'b1
  } cyc_kind_e;

  localparam int DEF_BUS_W = 8;
  localparam int DEF_SLOT_W = 5;
  localparam int DEF_FUNC_W = 3;
  localparam int DEF_OFS_W = 8;
  localparam int DEF_MAP_W = 16;
  localparam int DEF_LOW_SLOT_MAX = 12;
  localparam int DEF_CFG_CODE = 5;
endpackage

// File: rtl/cfgaddr_local_enc.sv
module cfgaddr_local_enc #(
  parameter int SLOT_W = 5,
  parameter int FUNC_W = 3,
  parameter int OFS_W = 8,
  parameter int MAP_W = 16,
  parameter int LOW_SLOT_MAX = 12,
  localparam int LOW_SLOTS = LOW_SLOT_MAX + 1,
  localparam int HIGH_SLOTS = MAP_W / 2,
  localparam int MAP_SEL_LSB = MAP_W - HIGH_SLOTS,
  localparam int ADDR_W = LOW_SLOTS + FUNC_W + OFS_W
) (
  input  logic [SLOT_W-1:0] slot,
  input  logic [FUNC_W-1:0] func,
  input  logic [OFS_W-1:0]  regofs,
  output logic [ADDR_W-1:0] addr,
  output logic [MAP_W-1:0]  map_hi,
  output logic              no_select
);
  logic [LOW_SLOTS-1:0]  addr_sel;
  logic [HIGH_SLOTS-1:0] map_sel;

  // one-hot select for the slots carried in the aperture offset
  for (genvar g = 0; g < LOW_SLOTS; g++) begin : g_addr_sel
    assign addr_sel[g] = (int'(slot) == g);
  end

  // one-hot select for the slots carried in the control word
  for (genvar h = 0; h < HIGH_SLOTS; h++) begin : g_map_sel
    assign map_sel[h] = (int'(slot) == LOW_SLOTS + h);
  end

  assign no_select = (int'(slot) >= LOW_SLOTS + HIGH_SLOTS);
  assign addr = {addr_sel, func, regofs[OFS_W-1:2], 2'b00};
  assign map_hi = {map_sel, {MAP_SEL_LSB{1'b0}}};
endmodule

// File: rtl/cfgaddr_fwd_enc.sv
module cfgaddr_fwd_enc #(
  parameter int BUS_W = 8,
  parameter int SLOT_W = 5,
  parameter int FUNC_W = 3,
  parameter int OFS_W = 8,
  localparam int ADDR_W = BUS_W + SLOT_W + FUNC_W + OFS_W
) (
  input  logic [BUS_W-1:0]  bus,
  input  logic [SLOT_W-1:0] slot,
  input  logic [FUNC_W-1:0] func,
  input  logic [OFS_W-1:0]  regofs,
  output logic [ADDR_W-1:0] addr
);
  assign addr = {bus, slot, func, regofs};
endmodule

// File: rtl/cfgaddr_oreg.sv
module cfgaddr_oreg #(
  parameter int DW = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          bad,
  input  logic [DW-1:0] din,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [DW-1:0] dout,
  output logic          err,
  output logic          in_ready
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      err       <= 1'b0;
      dout      <= '0;
    end else begin
      err <= take && bad;
      if (take) begin
        out_valid <= !bad;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      if (take && !bad) begin
        dout <= din;
      end
    end
  end
endmodule

// File: rtl/cfgaddr_gen.sv
module cfgaddr_gen
  import cfgaddr_pkg::*;
#(
  parameter int BUS_W = DEF_BUS_W,
  parameter int SLOT_W = DEF_SLOT_W,
  parameter int FUNC_W = DEF_FUNC_W,
  parameter int OFS_W = DEF_OFS_W,
  parameter int MAP_W = DEF_MAP_W,
  parameter int LOW_SLOT_MAX = DEF_LOW_SLOT_MAX,
  parameter int CFG_CODE = DEF_CFG_CODE,
  localparam int ADDR_W = BUS_W + SLOT_W + FUNC_W + OFS_W,
  localparam int DW = ADDR_W + MAP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BUS_W-1:0]  req_bus,
  input  logic [SLOT_W-1:0] req_slot,
  input  logic [FUNC_W-1:0] req_func,
  input  logic [OFS_W-1:0]  req_regofs,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic [MAP_W-1:0]  rsp_map,
  output logic              cfg_err
);
  cyc_kind_e         kind;
  logic [ADDR_W-1:0] loc_addr;
  logic [ADDR_W-1:0] fwd_addr;
  logic [MAP_W-1:0]  loc_map_hi;
  logic              loc_bad;
  logic [ADDR_W-1:0] nxt_addr;
  logic [MAP_W-1:0]  nxt_map;
  logic              take;
  logic              bad;
  logic [DW-1:0]     held;

  assign kind = (req_bus == '0) ? CYC_LOCAL : CYC_FORWARD;

  cfgaddr_local_enc #(
    .SLOT_W(SLOT_W), .FUNC_W(FUNC_W), .OFS_W(OFS_W),
    .MAP_W(MAP_W), .LOW_SLOT_MAX(LOW_SLOT_MAX)
  ) u_local (
    .slot(req_slot), .func(req_func), .regofs(req_regofs),
    .addr(loc_addr), .map_hi(loc_map_hi), .no_select(loc_bad)
  );

  cfgaddr_fwd_enc #(
    .BUS_W(BUS_W), .SLOT_W(SLOT_W), .FUNC_W(FUNC_W), .OFS_W(OFS_W)
  ) u_fwd (
    .bus(req_bus), .slot(req_slot), .func(req_func), .regofs(req_regofs),
    .addr(fwd_addr)
  );

  always_comb begin
    if (kind == CYC_LOCAL) begin
      nxt_addr = loc_addr;
      nxt_map  = {loc_map_hi[MAP_W-1:4], 3'(CFG_CODE), 1'b0};
    end else begin
      nxt_addr = fwd_addr;
      nxt_map  = {{(MAP_W-4){1'b0}}, 3'(CFG_CODE), 1'b1};
    end
  end

  assign take = req_valid && req_ready;
  assign bad  = (kind == CYC_LOCAL) && loc_bad;

  cfgaddr_oreg #(.DW(DW)) u_oreg (
    .clk(clk), .rst_n(rst_n), .take(take), .bad(bad),
    .din({nxt_map, nxt_addr}), .out_ready(rsp_ready),
    .out_valid(rsp_valid), .dout(held), .err(cfg_err),
    .in_ready(req_ready)
  );

  assign rsp_addr = held[ADDR_W-1:0];
  assign rsp_map  = held[DW-1:ADDR_W];
endmodule

// File: rtl/cfgaddr_gen_chk.sv
module cfgaddr_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [7:0]  req_bus,
  input logic [4:0]  req_slot,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [23:0] rsp_addr,
  input logic [15:0] rsp_map,
  input logic        cfg_err
);
  AST_TYPE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_map[3:1] == 3'b101); // R2
  AST_LOCAL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_map[0]) |-> $countones({rsp_addr[23:11], rsp_map[15:4]}) == 1); // R3
  AST_LOCAL_LOWBITS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_map[0]) |-> rsp_addr[1:0] == 2'b00); // R5
  AST_FWD_NO_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_map[0]) |-> rsp_map[15:4] == 12'h000); // R6
  AST_ERR_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !rsp_valid); // R7
  AST_ERR_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_bus == 8'h00 && req_slot > 5'd20) |=> cfg_err); // R7
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !(req_bus == 8'h00 && req_slot > 5'd20)) |=> rsp_valid); // R8
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_map)); // R9
  AST_STALL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready); // R9
endmodule

bind cfgaddr_gen cfgaddr_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_bus(req_bus), .req_slot(req_slot), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_addr(rsp_addr), .rsp_map(rsp_map),
  .cfg_err(cfg_err)
);

// File: tb/cfgaddr_gen_test.sv
`timescale 1ns/1ps
module cfgaddr_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_bus = '0;
  logic [4:0]  req_slot = '0;
  logic [2:0]  req_func = '0;
  logic [7:0]  req_regofs = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [23:0] rsp_addr;
  logic [15:0] rsp_map;
  logic        cfg_err;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cfgaddr_gen uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bus(req_bus), .req_slot(req_slot), .req_func(req_func),
    .req_regofs(req_regofs), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_addr(rsp_addr), .rsp_map(rsp_map), .cfg_err(cfg_err)
  );

  function automatic void model(input logic [7:0] b, input logic [4:0] s,
                                input logic [2:0] f, input logic [7:0] o,
                                output logic [23:0] a, output logic [15:0] m,
                                output logic e);
    e = 1'b0;
    a = '0;
    m = '0;
    if (b == 8'h00) begin
      m = 16'h000A;
      a[10:8] = f;
      a[7:2] = o[7:2];
      if (int'(s) <= 12) a[int'(s) + 11] = 1'b1;
      else if (int'(s) <= 20) m[int'(s) - 5] = 1'b1;
      else e = 1'b1;
    end else begin
      a = {b, s, f, o};
      m = 16'h000B;
    end
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input logic [4:0] s,
                      input logic [2:0] f, input logic [7:0] o, input string req);
    logic [23:0] ea;
    logic [15:0] em;
    logic        ee;
    model(b, s, f, o, ea, em, ee);
    @(negedge clk);
    req_bus = b; req_slot = s; req_func = f; req_regofs = o;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (ee) begin
      check(cfg_err && !rsp_valid, {req, " R7 err pulse"},
            {62'd0, cfg_err, rsp_valid}, 64'd2);
      @(negedge clk);
      check(!cfg_err, {req, " R7 single pulse"}, {63'd0, cfg_err}, 64'd0);
    end else begin
      check(rsp_valid && !cfg_err && rsp_addr == ea && rsp_map == em,
            {req, " R8 result"}, {22'd0, rsp_valid, cfg_err, rsp_map, rsp_addr},
            {22'd0, 2'b10, em, ea});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [23:0] keep_a;
    logic [15:0] keep_m;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R10 reset state
    check(!rsp_valid && !cfg_err && req_ready, "R10 reset",
          {61'd0, rsp_valid, cfg_err, req_ready}, 64'd1);
    rst_n = 1'b1;

    // R1 R3 R5: local cycle, low slot, register offset low bits dropped
    send(8'h00, 5'd0, 3'd0, 8'hFF, "R1 R3 R5 slot0");
    send(8'h00, 5'd12, 3'd7, 8'h03, "R3 slot12");
    // R4: boundary of the control-word select
    send(8'h00, 5'd13, 3'd2, 8'h40, "R4 slot13");
    send(8'h00, 5'd20, 3'd5, 8'hA5, "R4 slot20");
    // R7: no select bit
    send(8'h00, 5'd21, 3'd1, 8'h10, "R7 slot21");
    send(8'h00, 5'd31, 3'd1, 8'h10, "R7 slot31");
    // R6 R2: forward cycle keeps all fields, high slots valid
    send(8'h01, 5'd31, 3'd7, 8'hFF, "R6 bus1 slot31");
    send(8'hFF, 5'd21, 3'd0, 8'h01, "R6 R2 busFF");

    // R9: stalled consumer
    @(negedge clk);
    rsp_ready = 1'b0;
    req_bus = 8'h02; req_slot = 5'd3; req_func = 3'd4; req_regofs = 8'h1C;
    req_valid = 1'b1;
    @(negedge clk);
    keep_a = rsp_addr;
    keep_m = rsp_map;
    req_bus = 8'h00; req_slot = 5'd14; req_func = 3'd1; req_regofs = 8'h08;
    check(rsp_valid && !req_ready, "R9 ready low while stalled",
          {62'd0, rsp_valid, req_ready}, 64'd2);
    check(keep_a == {8'h02, 5'd3, 3'd4, 8'h1C}, "R9 first result",
          {40'd0, keep_a}, {40'd0, 8'h02, 5'd3, 3'd4, 8'h1C});
    repeat (2) @(negedge clk);
    check(rsp_valid && rsp_addr == keep_a && rsp_map == keep_m, "R9 hold",
          {23'd0, rsp_valid, rsp_map, rsp_addr}, {23'd1, keep_m, keep_a});
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid && rsp_addr == 24'h000108 && rsp_map == 16'h020A,
          "R9 R4 waiting request after release",
          {23'd0, rsp_valid, rsp_map, rsp_addr}, {23'd1, 16'h020A, 24'h000108});

    // random mix
    for (int i = 0; i < 300; i++) begin
      logic [7:0] b;
      b = ($urandom % 2 == 0) ? 8'h00 : 8'($urandom);
      send(b, 5'($urandom), 3'($urandom), 8'($urandom), "R1 R2 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule